// File: doc/BRIEF.md
# Shaper Rate Parameter Calculator

This block turns a requested transmit rate, given in Mbps, into the three numbers a token-bucket rate shaper is programmed with: an 8-bit base value, an up-shift exponent and a down-shift exponent. The shaper rate they encode is base × 2^up × 8 × 1000 / (tick × 2^down). The tick constant depends on the shaping level being programmed, which is chosen by a level select input. The calculation starts from a reference base of 126. It then searches the exponents one step at a time, evaluating the rate formula for each step with integer divisions. The exact search and rounding rules differ depending on whether the request lies above or below the reference rate.

A request is launched with a one-cycle `start_i`. The block reports `busy_o` while it works and pulses `done_o` for one cycle when the result is ready. All divisions run on a single restoring divider inside the block, which produces one quotient bit per cycle. A result is therefore ready after tens to hundreds of cycles.

With each result the block also returns two ready-to-write 32-bit shaping words:
- The peak-bucket word carries the computed rate fields and the burst fields taken from the inputs.
- The committed-bucket word carries the same burst fields with all rate fields at zero.

The recommended burst inputs are base 1 and shift 4.

Top module: `shp_rate_calc`

## Requirements
- R1: The level select maps 0 to tick 1536, 1 to tick 192, 2 to tick 48 and 3 to tick 1536. A level of 4 or more completes with `err_o` set.
- R2: A requested rate of zero completes with `err_o` set.
- R3: The reference is ref0 = (1008000 + tick/2 − 1) / tick, truncated. When ref0 equals the request, the result is base 126, up 0, down 0.
- R4: When ref0 exceeds the request, down is raised from 1 upward, with ref = 1008000 / (tick × 2^down) truncated, until ref ≤ request. An exact match gives base 126. Otherwise base = (request × tick × 2^down + 4000) / 8000, truncated. Up is 0 in both cases.
- R5: When ref0 is below the request, up is raised from 1 upward, with ref = (1008000 × 2^up + tick/2) / tick truncated, until ref ≥ request. An exact match gives base 126 with that up. Otherwise up is reduced by one and base = (request × tick + D/2) / D with D = 8000 × 2^up. Down is 0 in both cases.
- R6: If the upward search evaluates up = 15 and ref is still below the request, the block completes with `err_o` set.
- R7: The peak word holds base in bits [7:0], up in [11:8], down in [15:12], burst base in [20:16] and burst shift in [25:21]. Bits [31:26] are zero.
- R8: The committed word holds the same burst fields in bits [20:16] and [25:21], with bits [15:0] and [31:26] zero.
- R9: On an error, `base_o`, `up_exp_o`, `dn_exp_o` and both words are zero.
- R10: `done_o` is a one-cycle pulse. `busy_o` is high from the cycle after an accepted start until the cycle of `done_o`, and low during `done_o`. All result outputs change only in the `done_o` cycle and hold otherwise.
- R11: A `start_i` that arrives while `busy_o` is high is ignored. The running request completes unchanged and no extra `done_o` follows.
- R12: A `start_i` that arrives in the `done_o` cycle is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a calculation (one cycle) |
| rate_i | input | 32 | Requested rate in Mbps |
| level_i | input | 3 | Shaping level select |
| burst_base_i | input | 5 | Burst base field for both words |
| burst_shift_i | input | 5 | Burst shift field for both words |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | Result valid pulse |
| err_o | output | 1 | Request rejected or out of range |
| base_o | output | 8 | Computed base value |
| up_exp_o | output | 4 | Computed up-shift exponent |
| dn_exp_o | output | 4 | Computed down-shift exponent |
| peak_word_o | output | 32 | Packed peak-bucket shaping word |
| commit_word_o | output | 32 | Packed committed-bucket shaping word |

## Verification
Two events can meet in one cycle: the completion of a request and the acceptance of the next one. To provoke this, the bench raises `start_i` with new operands in the very cycle it sees `done_o`. It then judges two things. First, the old result must stay on the outputs while the new request is running. Second, the second `done_o` must deliver exactly the new request's values.

A start that arrives in the middle of a busy calculation is also driven. It must leave the running result untouched and must not produce an extra completion.

// File: rtl/shp_pkg.sv
package shp_pkg;
  localparam int CALC_W   = 48;
  localparam int EXP_W    = 4;
  localparam int BASE_W   = 8;
  localparam int BURST_W  = 5;
  localparam int TICK_W   = 11;
  localparam int WORD_W   = 32;
  localparam int REF_NUM  = 1008000;  // reference base x 8 x 1000
  localparam int REF_BASE = 126;
  localparam int UNIT_K   = 8000;
  localparam int HALF_K   = 4000;
  localparam int DEF_BURST_BASE  = 1;
  localparam int DEF_BURST_SHIFT = 4;

  typedef enum logic [1:0] {PH_REF, PH_DOWN, PH_UP, PH_BASE} phase_e;
  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  function automatic logic [TICK_W-1:0] tick_for(input logic [1:0] lvl);
    case (lvl)
      2'd1:    return TICK_W'(192);
      2'd2:    return TICK_W'(48);
      default: return TICK_W'(1536);
    endcase
  endfunction
endpackage

// File: rtl/shp_tick_lut.sv
module shp_tick_lut
  import shp_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0]  level_i,
  output logic [TICK_W-1:0] tick_o,
  output logic              valid_o
);
  localparam int NUM_LVL = 4;

  assign valid_o = (32'(level_i) < NUM_LVL);
  assign tick_o  = tick_for(level_i[1:0]);
endmodule

// File: rtl/shp_div.sv
module shp_div #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, dvs_q, rem_nx, quo_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [W:0]       rem_sh, diff;

  always_comb begin
    rem_sh = {rem_q, quo_q[W-1]};
    diff   = rem_sh - {1'b0, dvs_q};
    if (!diff[W]) begin
      rem_nx = diff[W-1:0];
      quo_nx = {quo_q[W-2:0], 1'b1};
    end else begin
      rem_nx = rem_sh[W-1:0];
      quo_nx = {quo_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= divisor_i;
        cnt_q <= CNT_W'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;

  AST_DIV_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> divisor_i != '0);  // R4
  AST_DIV_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);  // R10
endmodule

// File: rtl/shp_rate_calc.sv
module shp_rate_calc
  import shp_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int LVL_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [RATE_W-1:0]   rate_i,
  input  logic [LVL_W-1:0]    level_i,
  input  logic [BURST_W-1:0]  burst_base_i,
  input  logic [BURST_W-1:0]  burst_shift_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [BASE_W-1:0]   base_o,
  output logic [EXP_W-1:0]    up_exp_o,
  output logic [EXP_W-1:0]    dn_exp_o,
  output logic [WORD_W-1:0]   peak_word_o,
  output logic [WORD_W-1:0]   commit_word_o
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam int PAD_W = WORD_W - 2*BURST_W - BASE_W - 2*EXP_W;

  state_e              st_q, st_d;
  phase_e              ph_q, ph_d;
  logic [EXP_W-1:0]    u_q, u_d, s_q, s_d;
  logic [RATE_W-1:0]   rate_q, rate_d;
  logic [TICK_W-1:0]   tick_q, tick_d, lut_tick;
  logic                lut_ok;
  logic [BURST_W-1:0]  bb_q, bb_d, bs_q, bs_d;
  logic                go_q, go_d;
  logic [CALC_W-1:0]   dvd_q, dvd_d, dvs_q, dvs_d;
  logic                div_done;
  logic [CALC_W-1:0]   quot;

  logic                fin, fin_err;
  logic [BASE_W-1:0]   fin_base;
  logic [EXP_W-1:0]    fin_u, fin_s;

  logic                done_q, err_q;
  logic [BASE_W-1:0]   r_base_q;
  logic [EXP_W-1:0]    r_u_q, r_s_q;
  logic [BURST_W-1:0]  r_bb_q, r_bs_q;

  logic [CALC_W-1:0]   tick_w, rate_w, ref_w;

  shp_tick_lut #(.LVL_W(LVL_W)) u_lut (
    .level_i (level_i),
    .tick_o  (lut_tick),
    .valid_o (lut_ok)
  );

  shp_div #(.W(CALC_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (go_q),
    .dividend_i (dvd_q),
    .divisor_i  (dvs_q),
    .done_o     (div_done),
    .quot_o     (quot)
  );

  assign tick_w = CALC_W'(tick_q);
  assign rate_w = CALC_W'(rate_q);
  assign ref_w  = CALC_W'(REF_NUM);

  always_comb begin
    st_d = st_q;  ph_d = ph_q;  u_d = u_q;  s_d = s_q;
    rate_d = rate_q;  tick_d = tick_q;  bb_d = bb_q;  bs_d = bs_q;
    go_d = 1'b0;  dvd_d = dvd_q;  dvs_d = dvs_q;
    fin = 1'b0;  fin_err = 1'b0;  fin_base = '0;  fin_u = '0;  fin_s = '0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        rate_d = rate_i;  bb_d = burst_base_i;  bs_d = burst_shift_i;
        u_d = '0;  s_d = '0;
        if (!lut_ok || rate_i == '0) begin
          fin = 1'b1;  fin_err = 1'b1;
        end else begin
          st_d = ST_RUN;  ph_d = PH_REF;  tick_d = lut_tick;  go_d = 1'b1;
          dvd_d = ref_w + CALC_W'(lut_tick >> 1) - CALC_W'(1);
          dvs_d = CALC_W'(lut_tick);
        end
      end
      ST_RUN: if (div_done) begin
        unique case (ph_q)
          PH_REF: begin
            if (quot == rate_w) begin
              fin = 1'b1;  fin_base = BASE_W'(REF_BASE);
            end else if (quot > rate_w) begin
              ph_d = PH_DOWN;  s_d = EXP_W'(1);  go_d = 1'b1;
              dvd_d = ref_w;  dvs_d = tick_w << 1;
            end else begin
              ph_d = PH_UP;  u_d = EXP_W'(1);  go_d = 1'b1;
              dvd_d = (ref_w << 1) + (tick_w >> 1);  dvs_d = tick_w;
            end
          end
          PH_DOWN: begin
            if (quot == rate_w) begin
              fin = 1'b1;  fin_base = BASE_W'(REF_BASE);  fin_s = s_q;
            end else if (quot < rate_w) begin
              ph_d = PH_BASE;  go_d = 1'b1;
              dvd_d = ((rate_w * tick_w) << s_q) + CALC_W'(HALF_K);
              dvs_d = CALC_W'(UNIT_K);
            end else if (s_q == EXP_MAX) begin
              fin = 1'b1;  fin_err = 1'b1;
            end else begin
              s_d = s_q + 1'b1;  go_d = 1'b1;
              dvd_d = ref_w;  dvs_d = tick_w << (s_q + 1'b1);
            end
          end
          PH_UP: begin
            if (quot == rate_w) begin
              fin = 1'b1;  fin_base = BASE_W'(REF_BASE);  fin_u = u_q;
            end else if (quot > rate_w) begin
              ph_d = PH_BASE;  u_d = u_q - 1'b1;  go_d = 1'b1;
              dvd_d = rate_w * tick_w + (CALC_W'(HALF_K) << (u_q - 1'b1));
              dvs_d = CALC_W'(UNIT_K) << (u_q - 1'b1);
            end else if (u_q == EXP_MAX) begin
              fin = 1'b1;  fin_err = 1'b1;
            end else begin
              u_d = u_q + 1'b1;  go_d = 1'b1;
              dvd_d = (ref_w << (u_q + 1'b1)) + (tick_w >> 1);  dvs_d = tick_w;
            end
          end
          PH_BASE: begin
            fin = 1'b1;  fin_base = quot[BASE_W-1:0];  fin_u = u_q;  fin_s = s_q;
          end
          default: ;
        endcase
        if (fin) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  ph_q <= PH_REF;  u_q <= '0;  s_q <= '0;
      rate_q <= '0;  tick_q <= '0;  bb_q <= '0;  bs_q <= '0;
      go_q <= 1'b0;  dvd_q <= '0;  dvs_q <= CALC_W'(1);
      done_q <= 1'b0;  err_q <= 1'b0;  r_base_q <= '0;  r_u_q <= '0;
      r_s_q <= '0;  r_bb_q <= '0;  r_bs_q <= '0;
    end else begin
      st_q <= st_d;  ph_q <= ph_d;  u_q <= u_d;  s_q <= s_d;
      rate_q <= rate_d;  tick_q <= tick_d;  bb_q <= bb_d;  bs_q <= bs_d;
      go_q <= go_d;  dvd_q <= dvd_d;  dvs_q <= dvs_d;
      done_q <= fin;
      if (fin) begin
        err_q    <= fin_err;
        r_base_q <= fin_base;
        r_u_q    <= fin_u;
        r_s_q    <= fin_s;
        r_bb_q   <= fin_err ? '0 : bb_d;
        r_bs_q   <= fin_err ? '0 : bs_d;
      end
    end
  end

  assign busy_o        = (st_q == ST_RUN);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign base_o        = r_base_q;
  assign up_exp_o      = r_u_q;
  assign dn_exp_o      = r_s_q;
  assign peak_word_o   = {PAD_W'(0), r_bs_q, r_bb_q, r_s_q, r_u_q, r_base_q};
  assign commit_word_o = {PAD_W'(0), r_bs_q, r_bb_q, (BASE_W + 2*EXP_W)'(0)};

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);  // R10
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(peak_word_o) && $stable(err_o)));  // R10
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (peak_word_o == '0 && commit_word_o == '0));  // R9
  AST_ONE_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (up_exp_o == '0 || dn_exp_o == '0));  // R5
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !div_done) |=> busy_o);  // R11
endmodule

// File: tb/sim_shp_rate_calc.sv
module sim_shp_rate_calc;
  localparam int CLK_P = 10;
  localparam int WAIT_MAX = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] rate = '0;
  logic [2:0]  level = '0;
  logic [4:0]  bb = '0, bs = '0;
  logic        busy, done, err;
  logic [7:0]  base;
  logic [3:0]  up_e, dn_e;
  logic [31:0] pword, cword;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  shp_rate_calc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rate_i(rate), .level_i(level),
    .burst_base_i(bb), .burst_shift_i(bs), .busy_o(busy), .done_o(done), .err_o(err),
    .base_o(base), .up_exp_o(up_e), .dn_exp_o(dn_e), .peak_word_o(pword),
    .commit_word_o(cword)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input longint r, input int lvl, output int b,
                                output int u, output int s, output bit e);
    longint tk, rf, d;
    b = 0; u = 0; s = 0; e = 0;
    if (lvl >= 4 || r == 0) begin e = 1; return; end
    tk = (lvl == 1) ? 192 : (lvl == 2) ? 48 : 1536;
    rf = (1008000 + tk/2 - 1) / tk;
    if (rf == r) begin b = 126; return; end
    if (rf > r) begin
      while (rf > r) begin s++; rf = 1008000 / (tk << s); end
      b = (rf == r) ? 126 : int'((r * tk * (64'd1 << s) + 4000) / 8000);
    end else begin
      while (rf < r) begin
        if (u == 15) begin e = 1; u = 0; return; end
        u++; rf = ((64'd1008000 << u) + tk/2) / tk;
      end
      if (rf == r) b = 126;
      else begin u--; d = 8000 << u; b = int'((r * tk + d/2) / d); end
    end
  endfunction

  task automatic wait_done();
    int n = 0;
    while (!done && n < WAIT_MAX) begin @(negedge clk); n++; end
    chk(done, "R10 done timeout", done, 1);
  endtask

  task automatic launch(input longint r, input int lvl, input int b5, input int s5);
    rate = 32'(r); level = 3'(lvl); bb = 5'(b5); bs = 5'(s5); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_res(input string req, input longint r, input int lvl,
                           input int b5, input int s5);
    int eb, eu, es; bit ee;
    logic [31:0] pw, cw;
    model(r, lvl, eb, eu, es, ee);
    pw = ee ? 32'd0 : {6'd0, 5'(s5), 5'(b5), 4'(es), 4'(eu), 8'(eb)};
    cw = ee ? 32'd0 : {6'd0, 5'(s5), 5'(b5), 16'd0};
    chk(err == ee, {req, " err"}, err, ee);
    chk(base == 8'(eb), {req, " base"}, base, eb);
    chk(up_e == 4'(eu), {req, " up"}, up_e, eu);
    chk(dn_e == 4'(es), {req, " down"}, dn_e, es);
    chk(pword == pw, {req, " R7 peak word"}, pword, pw);
    chk(cword == cw, {req, " R8 commit word"}, cword, cw);
  endtask

  task automatic run(input string req, input longint r, input int lvl,
                     input int b5, input int s5);
    int eb, eu, es; bit ee;
    model(r, lvl, eb, eu, es, ee);
    launch(r, lvl, b5, s5);
    if (!ee) chk(busy, {req, " R10 busy after start"}, busy, 1);
    wait_done();
    check_res(req, r, lvl, b5, s5);
    @(negedge clk);
    chk(!done, {req, " R10 done one cycle"}, done, 0);
  endtask

  task automatic t_literal(input string req, input longint r, input int lvl,
                           input int b, input int u, input int s);
    run(req, r, lvl, 1, 4);
    chk(base == 8'(b) && up_e == 4'(u) && dn_e == 4'(s) && !err,
        {req, " literal"}, {base, up_e, dn_e}, {8'(b), 4'(u), 4'(s)});
  endtask

  task automatic t_busy_ignore();
    logic [31:0] held;
    launch(100000, 1, 3, 7);
    repeat (20) @(negedge clk);
    chk(busy, "R11 still busy", busy, 1);
    launch(21000, 2, 9, 2);  // ignored
    wait_done();
    check_res("R11 ignored start", 100000, 1, 3, 7);
    held = pword;
    repeat (200) begin
      @(negedge clk);
      chk(!done && !busy, "R11 no extra done", done, 0);
    end
    chk(pword == held, "R10 hold", pword, held);
  endtask

  task automatic t_back_to_back();
    logic [31:0] held;
    launch(500, 0, 1, 4);
    wait_done();
    check_res("R12 first", 500, 0, 1, 4);
    held = pword;
    launch(10500, 1, 2, 5);  // start raised in the done cycle
    chk(busy, "R12 accepted in done cycle", busy, 1);
    repeat (5) @(negedge clk);
    chk(pword == held, "R10 old result held", pword, held);
    wait_done();
    check_res("R12 second", 10500, 1, 2, 5);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && pword == 0 && cword == 0, "reset state", pword, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_literal("R3 level2 ref match", 21000, 2, 126, 0, 0);
    t_literal("R3 level1 ref match", 5250, 1, 126, 0, 0);
    t_literal("R4 down exact", 328, 0, 126, 0, 1);
    t_literal("R4 down rounded", 500, 0, 192, 0, 1);
    t_literal("R1 level3 tick 1536", 500, 3, 192, 0, 1);
    t_literal("R5 up exact", 10500, 1, 126, 1, 0);
    t_literal("R5 up rounded", 100000, 1, 150, 4, 0);
    run("R4 down deep", 1, 2, 1, 4);
    run("R5 up level2", 1000000, 2, 31, 31);
    run("R5 up level0", 77777, 0, 1, 4);
    run("R4 down level1", 3000, 1, 1, 4);
    run("R1 level4 error", 1000, 4, 1, 4);
    run("R1 level7 error", 1000, 7, 1, 4);
    run("R2 zero rate error", 0, 1, 1, 4);
    run("R6 up limit error", 64'hFFFF_FFFF, 2, 1, 4);
    run("R9 recover after error", 21000, 2, 1, 4);
    t_busy_ignore();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule